// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block sends asynchronous serial frames that carry one address/data marker bit after the payload. Software writes a byte and a marker value into a one-entry holding register. The transmitter moves that entry into its own shift register. It then sends a low start bit, 7 or 8 payload bits starting with the least significant, the marker bit, and one or two high stop bits. When no frame is in progress the line rests high.

Two flags report progress. The holding-empty flag tells software when it may write again. The line-done flag says the line has gone quiet. Each flag has an enable input, and the matching interrupt output is the flag gated by that enable. The transmitter looks at the holding-empty flag as it enters the final stop bit. If a new entry is waiting, that frame follows the stop bit with no gap. If nothing is waiting, the line-done flag is raised. An external one-cycle pulse paces every bit, and every state change happens on a system clock edge that carries that pulse.

Top module: `mpu_uart_tx`

## Requirements
- R1: A frame is a 0 start bit, then the payload with the least significant bit first, then the marker bit, then the stop bits at 1. The payload is 8 bits when cfg_seven is 0 and the low 7 bits when cfg_seven is 1. Each bit lasts exactly one bit_tick period, and txd changes only on clock edges where bit_tick is 1.
- R2: txd is 1 after reset and between frames, and it returns to 1 after the last stop bit of a frame that has no follower.
- R3: A write (wr_en = 1) stores wr_data and wr_mpb in the holding register, and empty_flag and end_flag read 0 from the next cycle on. A write wins over a load in the same cycle.
- R4: While idle, a tick edge that finds empty_flag at 0 loads the holding register, sets empty_flag to 1 and starts the start bit (txd = 0) at that same edge.
- R5: If empty_flag is 0 at the edge that begins the final stop bit, the held frame is loaded there and empty_flag goes to 1. end_flag stays 0, and that frame's start bit follows the stop bit directly.
- R6: If empty_flag is 1 at the edge that begins the final stop bit, end_flag is set to 1 at that edge, the stop bit completes, and the line stays at mark.
- R7: cfg_two_stop = 1 gives two stop bits and 0 gives one. cfg_seven and cfg_two_stop are sampled when a frame is loaded, and later changes do not alter a frame already loaded.
- R8: The payload and marker bit are latched at load, so a write during a frame does not change that frame.
- R9: txi_irq equals empty_flag AND tie_en, and tei_irq equals end_flag AND teie_en, as levels.
- R10: Reset sets empty_flag = 1, end_flag = 1 and txd = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cfg_seven | input | 1 | 1 selects a 7-bit payload |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tie_en | input | 1 | Enable for the holding-empty interrupt |
| teie_en | input | 1 | Enable for the line-done interrupt |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Payload to transmit |
| wr_mpb | input | 1 | Marker bit value for the frame |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding register is free |
| end_flag | output | 1 | Line has gone idle after a frame |
| txi_irq | output | 1 | Holding-empty interrupt level |
| tei_irq | output | 1 | Line-done interrupt level |

## Verification
The flags answer a write one clock edge later. A load sets empty_flag and drives txd low on the same tick edge that starts the frame. end_flag rises on the tick edge that begins the final stop bit, and each later bit appears on the next tick edge. The bench drives bit_tick and samples every output on the falling clock edge. It records txd once after each tick edge, so the line history holds exactly one entry per bit period, and frames and gap-free chaining are checked by index in that history.

// File: rtl/mpu_tx_pkg.sv
package mpu_tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_MPB,
        S_STOP1,
        S_STOP_LAST
    } tx_state_e;

    typedef struct packed {
        logic empty;
        logic done;
    } flag_t;
endpackage

// File: rtl/mpu_tx_hold.sv
module mpu_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mpb,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_mpb
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (wr_en) begin
            hold_d.data = wr_data;
            hold_d.mpb  = wr_mpb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold_data = hold_q.data;
    assign hold_mpb  = hold_q.mpb;
endmodule

// File: rtl/mpu_tx_flags.sv
module mpu_tx_flags
    import mpu_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic load_i,
    input  logic set_end_i,
    input  logic tie_en,
    input  logic teie_en,
    output logic empty_flag,
    output logic end_flag,
    output logic txi_irq,
    output logic tei_irq
);
    flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (load_i)    flag_d.empty = 1'b1;
        if (set_end_i) flag_d.done  = 1'b1;
        if (wr_en) begin
            flag_d.empty = 1'b0;
            flag_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '{empty: 1'b1, done: 1'b1};
        else        flag_q <= flag_d;
    end

    assign empty_flag = flag_q.empty;
    assign end_flag   = flag_q.done;
    assign txi_irq    = flag_q.empty & tie_en;
    assign tei_irq    = flag_q.done & teie_en;

    p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!empty_flag && !end_flag));
    p_load_sets_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !wr_en) |=> empty_flag);
    p_end_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_end_i && !wr_en) |=> end_flag);
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!txi_irq && !tei_irq));
endmodule

// File: rtl/mpu_tx_seq.sv
module mpu_tx_seq
    import mpu_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_mpb,
    input  logic              cfg_seven,
    input  logic              cfg_two_stop,
    output logic              load_o,
    output logic              set_end_o,
    output logic              txd
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              mpb;
        logic              short_len;
        logic              two_stop;
        logic              chain;
    } seq_t;

    seq_t seq_d, seq_q;

    logic idle_start;
    logic final_entry;
    logic [CNT_W-1:0] last_idx;

    assign last_idx    = seq_q.short_len ? LAST_SHORT : LAST_LONG;
    assign idle_start  = bit_tick && (seq_q.st == S_IDLE) && !empty_i;
    assign final_entry = bit_tick && (((seq_q.st == S_MPB) && !seq_q.two_stop)
                                      || (seq_q.st == S_STOP1));
    assign load_o      = idle_start || (final_entry && !empty_i);
    assign set_end_o   = final_entry && empty_i;

    always_comb begin
        seq_d = seq_q;
        if (bit_tick) begin
            case (seq_q.st)
                S_IDLE: begin
                    if (!empty_i) seq_d.st = S_START;
                end
                S_START: begin
                    seq_d.st  = S_DATA;
                    seq_d.cnt = '0;
                end
                S_DATA: begin
                    seq_d.shreg = seq_q.shreg >> 1;
                    if (seq_q.cnt == last_idx) seq_d.st = S_MPB;
                    else                       seq_d.cnt = seq_q.cnt + 1'b1;
                end
                S_MPB: begin
                    seq_d.st = seq_q.two_stop ? S_STOP1 : S_STOP_LAST;
                end
                S_STOP1: begin
                    seq_d.st = S_STOP_LAST;
                end
                S_STOP_LAST: begin
                    seq_d.st    = seq_q.chain ? S_START : S_IDLE;
                    seq_d.chain = 1'b0;
                end
                default: seq_d.st = S_IDLE;
            endcase
        end
        if (final_entry) seq_d.chain = !empty_i;
        if (load_o) begin
            seq_d.shreg     = hold_data;
            seq_d.mpb       = hold_mpb;
            seq_d.short_len = cfg_seven;
            seq_d.two_stop  = cfg_two_stop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        case (seq_q.st)
            S_START: txd = 1'b0;
            S_DATA:  txd = seq_q.shreg[0];
            S_MPB:   txd = seq_q.mpb;
            default: txd = 1'b1;
        endcase
    end

    p_no_tick_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));
    p_idle_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && seq_q.st == S_STOP_LAST && !seq_q.chain) |=> txd);
    p_load_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> !empty_i);
    p_chain_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && seq_q.st == S_STOP_LAST && seq_q.chain) |=> !txd);
    p_end_only_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_end_o |-> (empty_i && !load_o));
endmodule

// File: rtl/mpu_uart_tx.sv
module mpu_uart_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              cfg_seven,
    input  logic              cfg_two_stop,
    input  logic              tie_en,
    input  logic              teie_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mpb,
    output logic              txd,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              txi_irq,
    output logic              tei_irq
);
    logic [DATA_W-1:0] hold_data;
    logic              hold_mpb;
    logic              load;
    logic              set_end;

    mpu_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_mpb    (wr_mpb),
        .hold_data (hold_data),
        .hold_mpb  (hold_mpb)
    );

    mpu_tx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .load_i     (load),
        .set_end_i  (set_end),
        .tie_en     (tie_en),
        .teie_en    (teie_en),
        .empty_flag (empty_flag),
        .end_flag   (end_flag),
        .txi_irq    (txi_irq),
        .tei_irq    (tei_irq)
    );

    mpu_tx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .empty_i      (empty_flag),
        .hold_data    (hold_data),
        .hold_mpb     (hold_mpb),
        .cfg_seven    (cfg_seven),
        .cfg_two_stop (cfg_two_stop),
        .load_o       (load),
        .set_end_o    (set_end),
        .txd          (txd)
    );
endmodule

// File: tb/mpu_uart_tx_test.sv
module mpu_uart_tx_test;
    localparam int TP = 4;
    localparam int NVEC = 8;
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b0, 1'b0, 8'h3C},
        {1'b0, 1'b1, 1'b1, 8'h55},
        {1'b1, 1'b0, 1'b1, 8'h81},
        {1'b1, 1'b1, 1'b0, 8'h7E},
        {1'b0, 1'b0, 1'b1, 8'hFF},
        {1'b0, 1'b0, 1'b0, 8'h00},
        {1'b1, 1'b1, 1'b1, 8'h12}
    };

    logic clk = 0, rst_n = 0, bit_tick = 0;
    logic cfg_seven = 0, cfg_two_stop = 0, tie_en = 0, teie_en = 0;
    logic wr_en = 0, wr_mpb = 0;
    logic [7:0] wr_data = '0;
    logic txd, empty_flag, end_flag, txi_irq, tei_irq;

    int checks = 0, errors = 0, hn = 0, tcnt = 0;
    logic hist [0:1023];
    logic tick_at_edge = 0;
    bit done = 0;

    mpu_uart_tx #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_seven(cfg_seven),
        .cfg_two_stop(cfg_two_stop), .tie_en(tie_en), .teie_en(teie_en),
        .wr_en(wr_en), .wr_data(wr_data), .wr_mpb(wr_mpb), .txd(txd),
        .empty_flag(empty_flag), .end_flag(end_flag), .txi_irq(txi_irq),
        .tei_irq(tei_irq)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (tick_at_edge && hn < 1024) begin
            hist[hn] = txd;
            hn = hn + 1;
        end
        tcnt = (tcnt == TP - 1) ? 0 : tcnt + 1;
        bit_tick = (tcnt == TP - 1);
        tick_at_edge = bit_tick;
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int find_start(input int from);
        for (int i = from; i < hn; i++) if (hist[i] === 1'b0) return i;
        return hn;
    endfunction

    function automatic int frame_bits(input logic seven, input logic two);
        return 1 + (seven ? 7 : 8) + 1 + (two ? 2 : 1);
    endfunction

    task automatic check_frame(input int s, input logic [7:0] d, input logic mp,
                               input logic seven, input logic two, input string req);
        logic [15:0] got, exp;
        int len, nb;
        len = seven ? 7 : 8;
        nb = frame_bits(seven, two);
        got = '0; exp = '0;
        exp[0] = 1'b0;
        for (int i = 0; i < len; i++) exp[1 + i] = d[i];
        exp[len + 1] = mp;
        for (int i = len + 2; i < nb; i++) exp[i] = 1'b1;
        for (int i = 0; i < nb; i++) got[i] = (s + i < hn) ? hist[s + i] : 1'bx;
        chk(got === exp, req, got, exp);
    endtask

    task automatic write(input logic [7:0] d, input logic mp);
        wr_data = d; wr_mpb = mp; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TP) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int mark, s, s2, nb;
        repeat (3) @(negedge clk);
        // R10 reset values
        chk(empty_flag === 1'b1 && end_flag === 1'b1 && txd === 1'b1, "R10 reset",
            {13'b0, empty_flag, end_flag, txd}, 16'h7);
        // R9 interrupt gating after reset
        chk(txi_irq === 1'b0 && tei_irq === 1'b0, "R9 disabled", {14'b0, txi_irq, tei_irq}, 0);
        rst_n = 1;
        wait_ticks(2);
        tie_en = 1; teie_en = 1;
        #1;
        chk(txi_irq === 1'b1 && tei_irq === 1'b1, "R9 enabled", {14'b0, txi_irq, tei_irq}, 16'h3);
        // R2 idle line
        chk(txd === 1'b1, "R2 idle mark", txd, 1);

        for (int v = 0; v < NVEC; v++) begin
            cfg_two_stop = VEC[v][10];
            cfg_seven    = VEC[v][9];
            mark = (hn > 0) ? hn - 1 : 0;
            write(VEC[v][7:0], VEC[v][8]);
            // R3 flags clear the cycle after a write
            chk(empty_flag === 1'b0 && end_flag === 1'b0, "R3 write clears",
                {14'b0, empty_flag, end_flag}, 0);
            chk(txi_irq === 1'b0 && tei_irq === 1'b0, "R9 irq follows flags",
                {14'b0, txi_irq, tei_irq}, 0);
            while (!empty_flag) @(negedge clk);
            // R4 load and start bit at the same tick edge
            chk(txd === 1'b0, "R4 start on load", txd, 0);
            while (!end_flag) @(negedge clk);
            wait_ticks(3);
            s = find_start(mark);
            check_frame(s, VEC[v][7:0], VEC[v][8], VEC[v][9], VEC[v][10],
                        VEC[v][10] ? "R1 R7 frame" : "R1 frame");
            nb = frame_bits(VEC[v][9], VEC[v][10]);
            chk(hist[s + nb] === 1'b1, "R2 mark after stop", hist[s + nb], 1);
            // R6 done flag and interrupt level
            chk(end_flag === 1'b1 && tei_irq === 1'b1, "R6 end flag",
                {14'b0, end_flag, tei_irq}, 16'h3);
        end

        // R5 R7 R8 back-to-back with changes after the first load
        cfg_seven = 0; cfg_two_stop = 0;
        mark = hn - 1;
        write(8'hC3, 1'b1);
        while (!empty_flag) @(negedge clk);
        cfg_seven = 1; cfg_two_stop = 1;
        write(8'h2D, 1'b0);
        while (!empty_flag) @(negedge clk);
        chk(end_flag === 1'b0, "R5 no end when chained", end_flag, 0);
        while (!end_flag) @(negedge clk);
        wait_ticks(3);
        s = find_start(mark);
        check_frame(s, 8'hC3, 1'b1, 1'b0, 1'b0, "R8 R7 first frame unchanged");
        s2 = s + frame_bits(1'b0, 1'b0);
        check_frame(s2, 8'h2D, 1'b0, 1'b1, 1'b1, "R5 chained frame no gap");
        chk(hist[s2 + frame_bits(1'b1, 1'b1)] === 1'b1, "R2 mark after chain",
            hist[s2 + frame_bits(1'b1, 1'b1)], 1);

        // R9 disabling the enable drops the level
        teie_en = 0; tie_en = 0;
        #1;
        chk(tei_irq === 1'b0 && txi_irq === 1'b0 && end_flag === 1'b1, "R9 enable off",
            {13'b0, tei_irq, txi_irq, end_flag}, 16'h1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule